// File: doc/BRIEF.md
# Timer Slave Trigger Controller

This block is the control core of a general-purpose up-counter whose behaviour is steered by an external trigger. The trigger reaches the block as a level that is already synchronized to the clock. A 4-bit mode code selects what the trigger does. It can be ignored, or it can restart the count, gate it by level, start it, clock it edge by edge, or do a combination of these. The block holds the counter, the auto-reload compare, the enable flag, a one-cycle update pulse and two sticky event flags.

Normal counting advances on `tick_i`, a one-cycle advance strobe produced by a prescaler outside the block. When the count reaches the auto-reload limit, the next advance returns it to zero and pulses the update output. A restart caused by the trigger also clears the count, and it raises its own flag. That flag is kept separate from the one that records auto-reload wraps.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While `rst` is high, at every clock edge the count, the enable flag, the update pulse and both sticky flags go to 0.
- R2: Mode code 0: each cycle with `tick_i` high and the enable flag set advances the count by one. With the enable flag clear the count holds. The trigger has no effect on the count.
- R3: An advance taken when the count is greater than or equal to `reload_i` loads 0 instead of count+1. At the same edge it raises `upd_o` for that cycle and sets `wrap_flag_o`.
- R4: Mode code 4: a rising trigger edge clears the count, pulses `upd_o` and sets `trig_flag_o`. This takes priority over an advance in the same cycle.
- R5: Mode code 5: the count advances on enabled ticks only while the trigger level is high. When the level is low the count holds its value and is not cleared.
- R6: Mode code 6: a rising trigger edge sets the enable flag and leaves the count as it is. Counting then follows the ticks. A later edge changes nothing while the flag is set.
- R7: Mode code 7: with the enable flag set, the count advances once per rising trigger edge. `tick_i` is ignored.
- R8: Mode code 8: a rising trigger edge clears the count, pulses `upd_o`, sets `trig_flag_o` and sets the enable flag.
- R9: Mode code 9: the count advances on enabled ticks while the trigger level is high. A falling trigger edge clears the count and sets `trig_flag_o`, but does not pulse `upd_o`.
- R10: The trigger is registered twice. A change of `trig_i` sampled at clock edge k takes effect on the outputs at edge k+1, both as an edge and as a gating level.
- R11: Any other mode code (1–3, 10–15): the count holds and the trigger has no effect. The enable inputs and the flag clear still work.
- R12: `en_set_i` sets the enable flag and `en_clr_i` clears it; a set (from the input or from a trigger start) wins over a clear. `flags_clr_i` clears both sticky flags; a flag being set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Slave mode code |
| tick_i | input | 1 | Internal advance strobe |
| trig_i | input | 1 | Synchronized trigger level |
| reload_i | input | CNT_W | Auto-reload limit |
| en_set_i | input | 1 | Set enable flag |
| en_clr_i | input | 1 | Clear enable flag |
| flags_clr_i | input | 1 | Clear both sticky flags |
| cnt_o | output | CNT_W | Counter value |
| en_o | output | 1 | Enable flag |
| upd_o | output | 1 | One-cycle update event |
| trig_flag_o | output | 1 | Sticky: trigger-caused restart seen |
| wrap_flag_o | output | 1 | Sticky: auto-reload wrap seen |

## Verification
The bench makes a trigger edge land in the same cycle as a tick at the reload limit, and checks that the restart wins with a single update pulse. A design that let the wrap win would leave `trig_flag_o` clear and set `wrap_flag_o` by mistake. It uses a reload of zero, which makes the count wrap on every advance. It also lowers the reload below the current count, where a design that compares only for equality would run on toward overflow. It covers falling edges in mode 9, which must clear without an update pulse. It exercises mode 6 edges after the start, which must not disturb the count. It checks the one-cycle trigger latency directly: a design that acts on the raw input would clear the count one edge too early.

// File: rtl/tmr_slv_pkg.sv
package tmr_slv_pkg;

  typedef enum logic [3:0] {
    SM_FREE      = 4'd0,
    SM_RESTART   = 4'd4,
    SM_GATE      = 4'd5,
    SM_START     = 4'd6,
    SM_EXTCLK    = 4'd7,
    SM_RST_START = 4'd8,
    SM_GATE_CLR  = 4'd9
  } slv_mode_e;

  typedef struct packed {
    logic adv;      // advance the count this cycle
    logic reinit;   // trigger-caused clear
    logic upd_req;  // clear also pulses update
    logic start;    // trigger sets enable
  } slv_ctl_t;

endpackage

// File: rtl/tmr_trig_edge.sv
module tmr_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic samp_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= trig_i;
      prev_q <= samp_q;
    end
  end

  assign lvl_o  = samp_q;
  assign rise_o = samp_q & ~prev_q;
  assign fall_o = ~samp_q & prev_q;

  // R10: the level seen by the controls is the input from one edge earlier
  a_r10_sample_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lvl_o == $past(trig_i)));

endmodule

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
  import tmr_slv_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output slv_ctl_t   ctl_o
);

  slv_mode_e mode;
  assign mode = slv_mode_e'(mode_i);

  always_comb begin
    ctl_o = '0;
    unique case (mode)
      SM_FREE: begin
        ctl_o.adv = en_i & tick_i;
      end
      SM_RESTART: begin
        ctl_o.adv     = en_i & tick_i;
        ctl_o.reinit  = rise_i;
        ctl_o.upd_req = rise_i;
      end
      SM_GATE: begin
        ctl_o.adv = en_i & tick_i & lvl_i;
      end
      SM_START: begin
        ctl_o.adv   = en_i & tick_i;
        ctl_o.start = rise_i;
      end
      SM_EXTCLK: begin
        ctl_o.adv = en_i & rise_i;
      end
      SM_RST_START: begin
        ctl_o.adv     = en_i & tick_i;
        ctl_o.reinit  = rise_i;
        ctl_o.upd_req = rise_i;
        ctl_o.start   = rise_i;
      end
      SM_GATE_CLR: begin
        ctl_o.adv    = en_i & tick_i & lvl_i;
        ctl_o.reinit = fall_i;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             reinit_i,
  input  logic             upd_req_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             wrap_hit_o
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;
  logic             at_limit;

  assign at_limit   = (cnt_q >= reload_i);
  assign wrap_hit_o = adv_i & ~reinit_i & at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_ZERO;
      upd_q <= 1'b0;
    end else if (reinit_i) begin
      cnt_q <= CNT_ZERO;
      upd_q <= upd_req_i;
    end else if (adv_i) begin
      cnt_q <= at_limit ? CNT_ZERO : cnt_q + CNT_ONE;
      upd_q <= at_limit;
    end else begin
      upd_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !reinit_i && (cnt_o >= reload_i)) |=> (cnt_o == CNT_ZERO) && upd_o);

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !reinit_i && (cnt_o < reload_i)) |=> (cnt_o == $past(cnt_o) + CNT_ONE) && !upd_o);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !reinit_i) |=> $stable(cnt_o) && !upd_o);

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       mode_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             flags_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             upd_o,
  output logic             trig_flag_o,
  output logic             wrap_flag_o
);

  logic     lvl, rise, fall;
  logic     en_q, tflag_q, wflag_q;
  logic     wrap_hit;
  slv_ctl_t ctl;

  tmr_trig_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_mode_dec u_dec (
    .mode_i (mode_i),
    .en_i   (en_q),
    .tick_i (tick_i),
    .lvl_i  (lvl),
    .rise_i (rise),
    .fall_i (fall),
    .ctl_o  (ctl)
  );

  tmr_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .adv_i      (ctl.adv),
    .reinit_i   (ctl.reinit),
    .upd_req_i  (ctl.upd_req),
    .reload_i   (reload_i),
    .cnt_o      (cnt_o),
    .upd_o      (upd_o),
    .wrap_hit_o (wrap_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      tflag_q <= 1'b0;
      wflag_q <= 1'b0;
    end else begin
      if (en_set_i || ctl.start) en_q <= 1'b1;
      else if (en_clr_i)         en_q <= 1'b0;

      if (ctl.reinit)       tflag_q <= 1'b1;
      else if (flags_clr_i) tflag_q <= 1'b0;

      if (wrap_hit)         wflag_q <= 1'b1;
      else if (flags_clr_i) wflag_q <= 1'b0;
    end
  end

  assign en_o        = en_q;
  assign trig_flag_o = tflag_q;
  assign wrap_flag_o = wflag_q;

  a_r4_restart_edge: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'd4 && rise) |=> (cnt_o == '0) && upd_o && trig_flag_o);

  a_r6_start_sets_en: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'd6 && rise) |=> en_o);

  a_r8_restart_start: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'd8 && rise) |=> (cnt_o == '0) && upd_o && en_o && trig_flag_o);

  a_r9_fall_clears: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'd9 && fall) |=> (cnt_o == '0) && !upd_o && trig_flag_o);

  a_r11_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_i inside {4'd1, 4'd2, 4'd3, [4'd10:4'd15]}) |=> $stable(cnt_o) && !upd_o);

  a_r12_clr_only: assert property (@(posedge clk) disable iff (rst)
    (en_clr_i && !en_set_i && mode_i != 4'd6 && mode_i != 4'd8) |=> !en_o);

endmodule

// File: tb/tmr_slave_ctrl_tb_top.sv
module tmr_slave_ctrl_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   mode_i = '0;
  logic         tick_i = 1'b0;
  logic         trig_i = 1'b0;
  logic [W-1:0] reload_i = '0;
  logic         en_set_i = 1'b0;
  logic         en_clr_i = 1'b0;
  logic         flags_clr_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic         en_o, upd_o, trig_flag_o, wrap_flag_o;

  always #2 clk = ~clk;

  tmr_slave_ctrl #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .tick_i(tick_i), .trig_i(trig_i),
    .reload_i(reload_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .flags_clr_i(flags_clr_i), .cnt_o(cnt_o), .en_o(en_o), .upd_o(upd_o),
    .trig_flag_o(trig_flag_o), .wrap_flag_o(wrap_flag_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic         m_ts = 1'b0, m_tp = 1'b0;
  logic [W-1:0] m_cnt = '0;
  logic         m_en = 1'b0, m_upd = 1'b0, m_tf = 1'b0, m_wf = 1'b0;
  logic         m_wrapped = 1'b0;
  logic [3:0]   m_mode = '0;

  task automatic chk(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic string mode_tag(input logic [3:0] md);
    case (md)
      4'd0: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step(input logic [3:0] md, input logic tk, input logic tg,
                            input logic [W-1:0] ar, input logic es, input logic ec, input logic fc);
    logic rise, fall, adv, reinit, updr, start;
    rise = m_ts & ~m_tp;
    fall = ~m_ts & m_tp;
    adv = 1'b0; reinit = 1'b0; updr = 1'b0; start = 1'b0;
    case (md)
      4'd0: adv = m_en & tk;
      4'd4: begin adv = m_en & tk; reinit = rise; updr = rise; end
      4'd5: adv = m_en & tk & m_ts;
      4'd6: begin adv = m_en & tk; start = rise; end
      4'd7: adv = m_en & rise;
      4'd8: begin adv = m_en & tk; reinit = rise; updr = rise; start = rise; end
      4'd9: begin adv = m_en & tk & m_ts; reinit = fall; end
      default: ;
    endcase
    m_upd = 1'b0;
    m_wrapped = 1'b0;
    if (reinit) begin
      m_cnt = '0; m_upd = updr; m_tf = 1'b1;
    end else begin
      if (fc) m_tf = 1'b0;
      if (adv) begin
        if (m_cnt >= ar) begin
          m_cnt = '0; m_upd = 1'b1; m_wrapped = 1'b1;
        end else m_cnt = m_cnt + 1'b1;
      end
    end
    if (m_wrapped) m_wf = 1'b1;
    else if (fc) m_wf = 1'b0;
    if (es || start) m_en = 1'b1;
    else if (ec) m_en = 1'b0;
    m_tp = m_ts;
    m_ts = tg;
    m_mode = md;
  endtask

  task automatic cmp_all();
    string t;
    t = m_wrapped ? "R3" : mode_tag(m_mode);
    chk(t, "cnt", cnt_o, m_cnt);
    chk(t, "upd", W'(upd_o), W'(m_upd));
    chk("R12", "en", W'(en_o), W'(m_en));
    chk("R12", "trig_flag", W'(trig_flag_o), W'(m_tf));
    chk(m_wrapped ? "R3" : "R12", "wrap_flag", W'(wrap_flag_o), W'(m_wf));
  endtask

  task automatic cyc(input logic [3:0] md, input logic tk, input logic tg,
                     input logic [W-1:0] ar, input logic es, input logic ec, input logic fc);
    mode_i = md; tick_i = tk; trig_i = tg; reload_i = ar;
    en_set_i = es; en_clr_i = ec; flags_clr_i = fc;
    model_step(md, tk, tg, ar, es, ec, fc);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0]   md;
    logic [W-1:0] ar;
    logic         tg;
    int           s;
    s = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cnt", cnt_o, '0);
    chk("R1", "en", W'(en_o), '0);
    chk("R1", "upd", W'(upd_o), '0);
    chk("R1", "flags", W'({trig_flag_o, wrap_flag_o}), '0);
    rst = 1'b0;

    // R2 / R3 directed: count to reload 3, then wrap
    cyc(4'd0, 1'b0, 1'b0, 16'd3, 1'b1, 1'b0, 1'b0);
    chk("R12", "en after set", W'(en_o), W'(1));
    repeat (3) cyc(4'd0, 1'b1, 1'b0, 16'd3, 1'b0, 1'b0, 1'b0);
    chk("R2", "cnt after 3 ticks", cnt_o, 16'd3);
    cyc(4'd0, 1'b1, 1'b1, 16'd3, 1'b0, 1'b0, 1'b0);
    chk("R3", "wrap cnt", cnt_o, 16'd0);
    chk("R3", "wrap upd", W'(upd_o), W'(1));
    cyc(4'd0, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0, 1'b1);

    // R10 latency: in restart mode, trigger rise acts one edge later
    repeat (2) cyc(4'd4, 1'b1, 1'b0, 16'd9, 1'b0, 1'b0, 1'b0);
    cyc(4'd4, 1'b0, 1'b1, 16'd9, 1'b0, 1'b0, 1'b0);
    chk("R10", "cnt before act", cnt_o, 16'd2);
    chk("R10", "flag before act", W'(trig_flag_o), W'(0));
    cyc(4'd4, 1'b1, 1'b1, 16'd9, 1'b0, 1'b0, 1'b0);
    chk("R10", "cnt after act", cnt_o, 16'd0);
    chk("R4", "upd on restart", W'(upd_o), W'(1));
    chk("R4", "trig flag", W'(trig_flag_o), W'(1));

    // R4 corner: restart edge coincides with tick at limit
    cyc(4'd4, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b1);
    cyc(4'd4, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0, 1'b0);
    cyc(4'd4, 1'b1, 1'b1, 16'd0, 1'b0, 1'b0, 1'b0);
    chk("R4", "restart beats wrap", W'(wrap_flag_o), W'(0));

    // R3 corner: reload lowered below count
    repeat (5) cyc(4'd0, 1'b1, 1'b0, 16'd9, 1'b0, 1'b0, 1'b0);
    cyc(4'd0, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0, 1'b0);
    chk("R3", "above limit wraps", cnt_o, 16'd0);

    // constrained random segments
    tg = 1'b0;
    for (int seg = 0; seg < 70; seg++) begin
      case ($urandom % 9)
        0: md = 4'd0; 1: md = 4'd4; 2: md = 4'd5; 3: md = 4'd6;
        4: md = 4'd7; 5: md = 4'd8; 6: md = 4'd9;
        7: md = 4'd1 + 4'($urandom % 3);
        default: md = 4'd10 + 4'($urandom % 6);
      endcase
      ar = W'($urandom % 10);
      if (md == 4'd6 || md == 4'd8) cyc(md, 1'b0, tg, ar, 1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 45; k++) begin
        if ($urandom % 5 == 0) tg = ~tg;
        cyc(md, ($urandom % 4) != 0, tg, ar,
            ($urandom % 20) == 0, ($urandom % 30) == 0, ($urandom % 15) == 0);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule